// File: doc/BRIEF.md
# Zero High Bits Unit

This datapath block takes a source operand and a bit position, and returns the source with every bit at or above that position forced to zero. Bits below the position are left as they are. It works on either a 32-bit or a 64-bit operand, chosen by a mode input. Alongside the result it returns four status flags: zero, sign, carry and overflow.

The position comes from the low byte of a separate index operand. A position at or beyond the operand width clears nothing and raises the carry flag. The block takes operand values that have already been read and hands back only the result and the flags.

A parameter selects one of two forms. In the combinational form, the outputs follow the inputs directly. In the registered form, one output register adds a single cycle of latency.

Top module: `zhb_unit`

## Requirements
- R1: Only bits [7:0] of `idx_word` form the bit position; a change in bits [63:8] alone leaves the result and all flags unchanged.
- R2: Each result bit whose position is below the bit position equals the matching source bit, and each result bit at or above the bit position is 0.
- R3: When the bit position is greater than or equal to the operand width (64 when `wide_mode`=1, 32 when `wide_mode`=0), the result equals the source truncated to that width and `flag_carry` is 1; otherwise `flag_carry` is 0.
- R4: `flag_zero` is 1 exactly when the result is all zeros.
- R5: `flag_sign` equals result bit 63 when `wide_mode`=1 and result bit 31 when `wide_mode`=0.
- R6: `flag_ovf` is always 0.
- R7: When `wide_mode`=0, the operation uses only source bits [31:0], result bits [63:32] are 0, and the flags describe the 32-bit result.
- R8: A bit position of 0 gives a zero result with `flag_zero`=1 and `flag_carry`=0, in either mode.
- R9: With the output register enabled (OUT_REG=1, the default), the result and flags show the inputs one clock after the edge that captures them. While `rst_n` is low, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit operation |
| src_word | input | 64 | Source operand |
| idx_word | input | 64 | Index operand; the low byte is the bit position |
| res_word | output | 64 | Source with the high bits cleared |
| flag_zero | output | 1 | The result is zero |
| flag_sign | output | 1 | Most significant bit of the result at the selected width |
| flag_carry | output | 1 | The bit position reached or passed the operand width |
| flag_ovf | output | 1 | Overflow flag, always 0 |

## Verification
The vectors use all-ones sources, so that the exact cut position shows in the result. They also use alternating and sparse sources, which separate masking from passing data through, and which show whether the sign flag comes from the correct bit. The bit positions cover 0, one below the width, exactly the width, and far above the width. Together these separate an off-by-one error in the mask from an error in the saturation compare. Index words with garbage in their upper bytes show whether anything above the low byte leaks into the position. In 32-bit mode, the vectors set source bits above bit 31, so that any leak into the upper result half or into the flags becomes visible.

// File: rtl/zhb_pkg.sv
package zhb_pkg;
   typedef struct packed {
      logic zero;
      logic sign;
      logic carry;
      logic ovf;
   } zhb_flags_t;

   localparam int ZHB_FLAG_W = 4;
endpackage

// File: rtl/zhb_keep_mask.sv
module zhb_keep_mask #(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32,
   parameter int IDX_BITS = 8
) (
   input  logic                wide_mode,
   input  logic [IDX_BITS-1:0] bit_pos,
   output logic [WIDE_W-1:0]   keep_mask,
   output logic                saturated
);
   localparam int CMP_W = IDX_BITS + 1;

   logic [CMP_W-1:0] pos_ext;
   logic [CMP_W-1:0] span;

   assign pos_ext = {1'b0, bit_pos};
   assign span    = wide_mode ? CMP_W'(WIDE_W) : CMP_W'(NARROW_W);
   assign saturated = (pos_ext >= span);

   for (genvar b = 0; b < WIDE_W; b++) begin : g_bit
      if (b < NARROW_W) begin : g_low
         assign keep_mask[b] = (pos_ext > CMP_W'(b));
      end else begin : g_high
         assign keep_mask[b] = wide_mode && (pos_ext > CMP_W'(b));
      end
   end
endmodule

// File: rtl/zhb_flag_gen.sv
module zhb_flag_gen
   import zhb_pkg::*;
#(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic              wide_mode,
   input  logic [WIDE_W-1:0] result,
   input  logic              saturated,
   output zhb_flags_t        flags
);
   always_comb begin
      flags.zero  = ~|result;
      flags.sign  = wide_mode ? result[WIDE_W-1] : result[NARROW_W-1];
      flags.carry = saturated;
      flags.ovf   = 1'b0;
   end
endmodule

// File: rtl/zhb_out_stage.sv
module zhb_out_stage
   import zhb_pkg::*;
#(
   parameter int WIDE_W  = 64,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDE_W-1:0] d_res,
   input  zhb_flags_t        d_flags,
   output logic [WIDE_W-1:0] q_res,
   output zhb_flags_t        q_flags
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_res   <= '0;
            q_flags <= '0;
         end else begin
            q_res   <= d_res;
            q_flags <= d_flags;
         end
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign q_res   = d_res;
      assign q_flags = d_flags;
   end
endmodule

// File: rtl/zhb_unit.sv
module zhb_unit
   import zhb_pkg::*;
#(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32,
   parameter int IDX_BITS = 8,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic [WIDE_W-1:0] src_word,
   input  logic [WIDE_W-1:0] idx_word,
   output logic [WIDE_W-1:0] res_word,
   output logic              flag_zero,
   output logic              flag_sign,
   output logic              flag_carry,
   output logic              flag_ovf
);
   if (NARROW_W >= WIDE_W) begin : g_bad_narrow
      $error("zhb_unit: NARROW_W must be below WIDE_W");
   end
   if (IDX_BITS >= WIDE_W) begin : g_bad_idx
      $error("zhb_unit: IDX_BITS must be below WIDE_W");
   end
   if ((1 << IDX_BITS) <= WIDE_W) begin : g_bad_range
      $error("zhb_unit: IDX_BITS too narrow to reach the full width");
   end

   logic [IDX_BITS-1:0] bit_pos;
   logic                unused_idx_hi;
   logic [WIDE_W-1:0]   keep_mask;
   logic                saturated;
   logic [WIDE_W-1:0]   cleared;
   zhb_flags_t          flags_d;
   zhb_flags_t          flags_q;

   assign bit_pos       = idx_word[IDX_BITS-1:0];
   assign unused_idx_hi = ^idx_word[WIDE_W-1:IDX_BITS];

   zhb_keep_mask #(
      .WIDE_W   (WIDE_W),
      .NARROW_W (NARROW_W),
      .IDX_BITS (IDX_BITS)
   ) u_mask (
      .wide_mode (wide_mode),
      .bit_pos   (bit_pos),
      .keep_mask (keep_mask),
      .saturated (saturated)
   );

   assign cleared = src_word & keep_mask;

   zhb_flag_gen #(
      .WIDE_W   (WIDE_W),
      .NARROW_W (NARROW_W)
   ) u_flags (
      .wide_mode (wide_mode),
      .result    (cleared),
      .saturated (saturated),
      .flags     (flags_d)
   );

   zhb_out_stage #(
      .WIDE_W  (WIDE_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_res   (cleared),
      .d_flags (flags_d),
      .q_res   (res_word),
      .q_flags (flags_q)
   );

   assign flag_zero  = flags_q.zero;
   assign flag_sign  = flags_q.sign;
   assign flag_carry = flags_q.carry;
   assign flag_ovf   = flags_q.ovf;
endmodule

// File: rtl/zhb_unit_chk.sv
module zhb_unit_chk #(
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32,
   parameter int IDX_BITS = 8,
   parameter bit OUT_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wide_mode,
   input logic [WIDE_W-1:0] src_word,
   input logic [WIDE_W-1:0] idx_word,
   input logic [WIDE_W-1:0] res_word,
   input logic              flag_zero,
   input logic              flag_sign,
   input logic              flag_carry,
   input logic              flag_ovf
);
   localparam int CMP_W = IDX_BITS + 1;

   logic                primed;
   logic                wide_s;
   logic [WIDE_W-1:0]   src_s;
   logic [IDX_BITS-1:0] pos_s;
   logic [CMP_W-1:0]    span_s;
   logic [WIDE_W-1:0]   src_trunc;

   if (OUT_REG) begin : g_lat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            primed <= 1'b0;
            wide_s <= 1'b0;
            src_s  <= '0;
            pos_s  <= '0;
         end else begin
            primed <= 1'b1;
            wide_s <= wide_mode;
            src_s  <= src_word;
            pos_s  <= idx_word[IDX_BITS-1:0];
         end
      end
   end else begin : g_now
      assign primed = 1'b1;
      assign wide_s = wide_mode;
      assign src_s  = src_word;
      assign pos_s  = idx_word[IDX_BITS-1:0];
   end

   assign span_s    = wide_s ? CMP_W'(WIDE_W) : CMP_W'(NARROW_W);
   assign src_trunc = wide_s ? src_s : {{(WIDE_W-NARROW_W){1'b0}}, src_s[NARROW_W-1:0]};

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      flag_ovf == 1'b0);

   a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (flag_zero == (res_word == '0)));

   a_r3_carry_flag: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (flag_carry == ({1'b0, pos_s} >= span_s)));

   a_r3_saturate_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && flag_carry) |-> (res_word == src_trunc));

   a_r5_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (flag_sign == (wide_s ? res_word[WIDE_W-1] : res_word[NARROW_W-1])));

   a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !wide_s) |-> (res_word[WIDE_W-1:NARROW_W] == '0));

   a_r2_subset_of_src: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> ((res_word & ~src_s) == '0));

   a_r8_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && pos_s == '0) |-> (res_word == '0 && flag_zero && !flag_carry));
endmodule

bind zhb_unit zhb_unit_chk #(
   .WIDE_W   (WIDE_W),
   .NARROW_W (NARROW_W),
   .IDX_BITS (IDX_BITS),
   .OUT_REG  (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wide_mode  (wide_mode),
   .src_word   (src_word),
   .idx_word   (idx_word),
   .res_word   (res_word),
   .flag_zero  (flag_zero),
   .flag_sign  (flag_sign),
   .flag_carry (flag_carry),
   .flag_ovf   (flag_ovf)
);

// File: tb/sim_zhb_unit.sv
`timescale 1ns/1ps
module sim_zhb_unit;
   typedef struct packed {
      logic        wide;
      logic [63:0] src;
      logic [63:0] idx;
      logic [63:0] res;
      logic [3:0]  flg;   // {zero, sign, carry, ovf}
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8,   64'h0000_0000_0000_00FF, 4'b0000},
      '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63,  64'h7FFF_FFFF_FFFF_FFFF, 4'b0000},
      '{1'b1, 64'h8000_0000_0000_0001, 64'd64,  64'h8000_0000_0000_0001, 4'b0110},
      '{1'b1, 64'h8000_0000_0000_0001, 64'd200, 64'h8000_0000_0000_0001, 4'b0110},
      '{1'b1, 64'h1234_5678_9ABC_DEF0, 64'd0,   64'h0,                   4'b1000},
      '{1'b1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FF10, 64'h0000_0000_0000_DEF0, 4'b0000},
      '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0100, 64'h0,   4'b1000},
      '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32,  64'h0000_0000_FFFF_FFFF, 4'b0110},
      '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd31,  64'h0000_0000_7FFF_FFFF, 4'b0000},
      '{1'b0, 64'hABCD_0000_8000_0000, 64'd40,  64'h0000_0000_8000_0000, 4'b0110},
      '{1'b0, 64'hFFFF_FFFF_0000_0000, 64'd20,  64'h0,                   4'b1000},
      '{1'b1, 64'h0000_0000_0000_0F00, 64'd8,   64'h0,                   4'b1000},
      '{1'b0, 64'h0000_0000_8000_0000, 64'd255, 64'h0000_0000_8000_0000, 4'b0110},
      '{1'b1, 64'hA5A5_A5A5_A5A5_A5A5, 64'd33,  64'h0000_0001_A5A5_A5A5, 4'b0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic [63:0] src_word = '0;
   logic [63:0] idx_word = '0;
   logic [63:0] res_word;
   logic        flag_zero, flag_sign, flag_carry, flag_ovf;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   zhb_unit u0 (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
      .src_word(src_word), .idx_word(idx_word), .res_word(res_word),
      .flag_zero(flag_zero), .flag_sign(flag_sign),
      .flag_carry(flag_carry), .flag_ovf(flag_ovf)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic w, input logic [63:0] s, input logic [63:0] i);
      @(negedge clk);
      wide_mode = w;
      src_word  = s;
      idx_word  = i;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R9: outputs held at zero during reset, whatever the inputs
      wide_mode = 1'b1;
      src_word  = 64'hFFFF_FFFF_FFFF_FFFF;
      idx_word  = 64'd64;
      repeat (3) @(negedge clk);
      check("R9 reset result", res_word, 64'h0);
      check("R9 reset flags", {60'h0, flag_zero, flag_sign, flag_carry, flag_ovf}, 64'h0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         apply(VECS[k].wide, VECS[k].src, VECS[k].idx);
         check("R2 result", res_word, VECS[k].res);
         check("R4 zero flag", {63'h0, flag_zero}, {63'h0, VECS[k].flg[3]});
         check("R5 sign flag", {63'h0, flag_sign}, {63'h0, VECS[k].flg[2]});
         check("R3 carry flag", {63'h0, flag_carry}, {63'h0, VECS[k].flg[1]});
         check("R6 overflow flag", {63'h0, flag_ovf}, 64'h0);
      end

      // R1: upper index bits ignored, same result as the bare low byte
      apply(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0010);
      check("R1 plain index", res_word, 64'h0000_0000_0000_FFFF);
      apply(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0000_3710);
      check("R1 garbage upper index", res_word, 64'h0000_0000_0000_FFFF);
      check("R1 carry unchanged", {63'h0, flag_carry}, 64'h0);

      // R7: narrow mode ignores source upper half
      apply(1'b0, 64'hFFFF_0000_0000_FFFF, 64'd16);
      check("R7 narrow result", res_word, 64'h0000_0000_0000_FFFF);
      apply(1'b0, 64'h8000_0000_0000_0000, 64'd64);
      check("R7 narrow result upper only", res_word, 64'h0);
      check("R7 narrow zero flag", {63'h0, flag_zero}, 64'h1);
      check("R7 narrow sign flag", {63'h0, flag_sign}, 64'h0);

      // R8: index zero in both modes
      apply(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      check("R8 narrow result", res_word, 64'h0);
      check("R8 narrow flags", {60'h0, flag_zero, flag_sign, flag_carry, flag_ovf}, 64'h8);
      apply(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF00);
      check("R8 wide result", res_word, 64'h0);
      check("R8 wide flags", {60'h0, flag_zero, flag_sign, flag_carry, flag_ovf}, 64'h8);

      // R9: one cycle latency - old result visible until the capturing edge
      apply(1'b1, 64'h0000_0000_0000_00F0, 64'd64);
      @(negedge clk);
      wide_mode = 1'b1;
      src_word  = 64'hFFFF_FFFF_FFFF_FFFF;
      idx_word  = 64'd4;
      #1;
      check("R9 held before edge", res_word, 64'h0000_0000_0000_00F0);
      @(negedge clk);
      check("R9 new after edge", res_word, 64'h0000_0000_0000_000F);

      // R9: asynchronous reset clears outputs
      rst_n = 1'b0;
      #1;
      check("R9 async reset result", res_word, 64'h0);
      check("R9 async reset flags", {60'h0, flag_zero, flag_sign, flag_carry, flag_ovf}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end
endmodule